// File: doc/BRIEF.md
# Programmed-I/O Byte FIFO with Command Capture

This block is the byte queue behind a single host data port used for programmed transfers. Each host write adds one byte to a small circular FIFO. Each host read takes the oldest byte out and raises an interrupt event. When the controller is collecting a command, host writes go to a separate command buffer and the FIFO is not touched. A status request loads the two-byte status-phase response into the FIFO. That response is the status byte followed by a zero byte. The request also sets the flags value to 2 and raises the interrupt.

The FIFO count is kept at least one below the depth. A write that arrives when only one slot is left is dropped, and the block reports an overrun event for it. Both pointers return to zero whenever the count drops to zero. A read during the data-out phase still uses up a count, but it returns zero and leaves the read pointer where it was.

The write side is a valid/ready stream. `wr_ready` is high unless a flush, a status request or a read is asserted in the same cycle. Those actions take priority in the order flush, status, read, write, so a write beat with `wr_ready` low is not taken and the host must hold it. A write beat that is taken but finds the FIFO at its limit is consumed and dropped. Reads are single-cycle requests: `rd_valid` pulses one cycle later, and `rd_data` holds the data-port value.

Top module: `pio_cmd_fifo`

## Requirements
- R1: After reset, count, both pointers, command length, flags and `rd_data` are zero, and `irq`, `overrun` and `rd_valid` are low.
- R2: An accepted write outside command mode with count below DEPTH-1 stores the byte at the write pointer. One cycle later the count is one higher and the write pointer has advanced, wrapping from DEPTH-1 to 0.
- R3: A write at count DEPTH-1 is dropped. The count and pointers stay unchanged, and `overrun` pulses high for exactly one cycle.
- R4: A read with a nonzero count, outside the data-out phase, returns the oldest byte in FIFO order. It lowers the count by one, advances the read pointer and pulses `irq` one cycle later.
- R5: A read with a nonzero count while `phase_dout` is 1 returns 0 and lowers the count by one. It leaves the read pointer unchanged and pulses `irq`.
- R6: A read with a zero count does not change `rd_data` and leaves the count and pointers at zero. It does not pulse `irq`, but `rd_valid` still pulses.
- R7: Whenever the count reaches zero through a read, both pointers are zero in the same cycle.
- R8: While `cmd_mode` is 1, an accepted write stores its byte at index `cmd_len` of the command buffer and increments `cmd_len`. The FIFO count and pointers are unchanged.
- R9: Once `cmd_len` equals CMD_DEPTH, further command writes are ignored and the stored bytes are kept.
- R10: `cmd_clear` sets `cmd_len` to zero and takes priority over a command write in the same cycle.
- R11: A status request gives count 2, read pointer 0, write pointer 2 mod DEPTH and flags 2, and pulses `irq`. The next two reads return `status_val` and then 0.
- R12: `flush` sets the count, both pointers and flags to zero one cycle later.
- R13: `wr_ready` is low whenever `flush`, `status_req` or `rd_req` is high. Only the highest-priority action (flush, status, read, write) takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty the FIFO and clear flags |
| cmd_mode | input | 1 | Route host writes to the command buffer |
| cmd_clear | input | 1 | Reset the command length to zero |
| phase_dout | input | 1 | Bus phase is data-out; reads return zero |
| wr_valid | input | 1 | Host write beat present |
| wr_ready | output | 1 | Write beat accepted this cycle |
| wr_data | input | 8 | Host write byte |
| rd_req | input | 1 | Host read of the data port |
| rd_valid | output | 1 | Pulse one cycle after each read request |
| rd_data | output | 8 | Data-port value |
| status_req | input | 1 | Load the two-byte status response |
| status_val | input | 8 | Status byte for the response |
| cmd_rd_idx | input | $clog2(CMD_DEPTH) | Command buffer inspection index |
| cmd_rd_data | output | 8 | Command byte at `cmd_rd_idx` |
| cmd_len | output | $clog2(CMD_DEPTH+1) | Number of captured command bytes |
| count | output | $clog2(DEPTH+1) | FIFO byte count |
| rd_ptr | output | $clog2(DEPTH) | FIFO read pointer |
| wr_ptr | output | $clog2(DEPTH) | FIFO write pointer |
| flags | output | 5 | FIFO flags value (2 after status, 0 after flush) |
| irq | output | 1 | Interrupt event pulse |
| overrun | output | 1 | Dropped-write event pulse |

## Verification
The bench builds the block with DEPTH=4 and CMD_DEPTH=8. With these sizes the overrun limit is reached after three writes, and the pointers wrap after a handful of mixed operations. The command buffer fills after eight writes. This makes it possible to sweep every fill level, every pointer wrap position and both full conditions completely, each compared against an arithmetic model of count and pointers.

// File: rtl/pio_cmd_fifo_pkg.sv
package pio_cmd_fifo_pkg;
  localparam int FLAG_W = 5;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_FLUSH,
    ACT_STATUS,
    ACT_READ,
    ACT_WRITE_FIFO,
    ACT_WRITE_CMD
  } act_e;
endpackage

// File: rtl/pio_arbiter.sv
module pio_arbiter
  import pio_cmd_fifo_pkg::*;
(
  input  logic flush,
  input  logic status_req,
  input  logic rd_req,
  input  logic wr_valid,
  input  logic cmd_mode,
  output act_e act,
  output logic wr_ready
);
  // Fixed priority: flush, status, read, write.
  always_comb begin
    if (flush)           act = ACT_FLUSH;
    else if (status_req) act = ACT_STATUS;
    else if (rd_req)     act = ACT_READ;
    else if (wr_valid)   act = cmd_mode ? ACT_WRITE_CMD : ACT_WRITE_FIFO;
    else                 act = ACT_NONE;
  end

  assign wr_ready = !(flush || status_req || rd_req);
endmodule

// File: rtl/pio_byte_fifo.sv
module pio_byte_fifo
  import pio_cmd_fifo_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  act_e                       act,
  input  logic [BYTE_W-1:0]          wr_data,
  input  logic                       phase_dout,
  input  logic [BYTE_W-1:0]          status_val,
  output logic [BYTE_W-1:0]          rd_data,
  output logic                       rd_valid,
  output logic                       irq,
  output logic                       overrun,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic [$clog2(DEPTH)-1:0]   rd_ptr,
  output logic [$clog2(DEPTH)-1:0]   wr_ptr,
  output logic [FLAG_W-1:0]          flags
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic              at_limit;

  assign at_limit = (count == CW'(DEPTH - 1));

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (act == ACT_STATUS) begin
      mem[0]      <= status_val;
      mem[PW'(1)] <= '0;
    end else if (act == ACT_WRITE_FIFO && !at_limit) begin
      mem[wr_ptr] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      flags    <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
      irq      <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      irq      <= 1'b0;
      overrun  <= 1'b0;
      case (act)
        ACT_FLUSH: begin
          count  <= '0;
          rd_ptr <= '0;
          wr_ptr <= '0;
          flags  <= '0;
        end
        ACT_STATUS: begin
          count  <= CW'(2);
          rd_ptr <= '0;
          wr_ptr <= PW'(2 % DEPTH);
          flags  <= FLAG_W'(2);
          irq    <= 1'b1;
        end
        ACT_READ: begin
          rd_valid <= 1'b1;
          if (count != '0) begin
            rd_data <= phase_dout ? '0 : mem[rd_ptr];
            irq     <= 1'b1;
            count   <= count - 1'b1;
            if (count == CW'(1)) begin
              rd_ptr <= '0;
              wr_ptr <= '0;
            end else if (!phase_dout) begin
              rd_ptr <= ptr_inc(rd_ptr);
            end
          end else begin
            rd_ptr <= '0;
            wr_ptr <= '0;
          end
        end
        ACT_WRITE_FIFO: begin
          if (at_limit) begin
            overrun <= 1'b1;
          end else begin
            count  <= count + 1'b1;
            wr_ptr <= ptr_inc(wr_ptr);
          end
        end
        default: ;
      endcase
    end
  end

  // R3: the count never reaches the full depth
  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH - 1));
  // R3: a dropped write leaves the count untouched
  p_overrun_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> count == $past(count));
  // R4: every pop of a nonempty FIFO raises the interrupt
  p_pop_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_READ && count != '0) |=> irq);
  // R6: empty reads have no side effects on the data port
  p_empty_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_READ && count == '0) |=> (!irq && $stable(rd_data)));
  // R7: empty FIFO means both pointers rewound
  p_rewind_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> (rd_ptr == '0 && wr_ptr == '0));
  // R12: flush empties the FIFO
  p_flush_empty_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_FLUSH) |=> (count == '0 && flags == '0));
endmodule

// File: rtl/pio_cmd_capture.sv
module pio_cmd_capture
  import pio_cmd_fifo_pkg::*;
#(
  parameter int CMD_DEPTH = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  act_e                           act,
  input  logic                           cmd_clear,
  input  logic [BYTE_W-1:0]              wr_data,
  input  logic [$clog2(CMD_DEPTH)-1:0]   rd_idx,
  output logic [BYTE_W-1:0]              rd_byte,
  output logic [$clog2(CMD_DEPTH+1)-1:0] cmd_len
);
  localparam int IW = $clog2(CMD_DEPTH);
  localparam int LW = $clog2(CMD_DEPTH + 1);

  logic [BYTE_W-1:0] cbuf [CMD_DEPTH];
  logic              take;

  assign take    = (act == ACT_WRITE_CMD) && !cmd_clear && (cmd_len < LW'(CMD_DEPTH));
  assign rd_byte = cbuf[rd_idx];

  always_ff @(posedge clk) begin
    if (take) cbuf[cmd_len[IW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cmd_len <= '0;
    else if (cmd_clear) cmd_len <= '0;
    else if (take)      cmd_len <= cmd_len + 1'b1;
  end

  // R9: the command length never passes the buffer size
  p_cmd_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_len <= LW'(CMD_DEPTH));
  // R10: a clear always lands
  p_cmd_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clear |=> cmd_len == '0);
endmodule

// File: rtl/pio_cmd_fifo.sv
module pio_cmd_fifo
  import pio_cmd_fifo_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int CMD_DEPTH = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           flush,
  input  logic                           cmd_mode,
  input  logic                           cmd_clear,
  input  logic                           phase_dout,
  input  logic                           wr_valid,
  output logic                           wr_ready,
  input  logic [7:0]                     wr_data,
  input  logic                           rd_req,
  output logic                           rd_valid,
  output logic [7:0]                     rd_data,
  input  logic                           status_req,
  input  logic [7:0]                     status_val,
  input  logic [$clog2(CMD_DEPTH)-1:0]   cmd_rd_idx,
  output logic [7:0]                     cmd_rd_data,
  output logic [$clog2(CMD_DEPTH+1)-1:0] cmd_len,
  output logic [$clog2(DEPTH+1)-1:0]     count,
  output logic [$clog2(DEPTH)-1:0]       rd_ptr,
  output logic [$clog2(DEPTH)-1:0]       wr_ptr,
  output logic [4:0]                     flags,
  output logic                           irq,
  output logic                           overrun
);
  act_e act;

  pio_arbiter u_arb (
    .flush      (flush),
    .status_req (status_req),
    .rd_req     (rd_req),
    .wr_valid   (wr_valid),
    .cmd_mode   (cmd_mode),
    .act        (act),
    .wr_ready   (wr_ready)
  );

  pio_byte_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .act        (act),
    .wr_data    (wr_data),
    .phase_dout (phase_dout),
    .status_val (status_val),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .irq        (irq),
    .overrun    (overrun),
    .count      (count),
    .rd_ptr     (rd_ptr),
    .wr_ptr     (wr_ptr),
    .flags      (flags)
  );

  pio_cmd_capture #(.CMD_DEPTH(CMD_DEPTH)) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .act       (act),
    .cmd_clear (cmd_clear),
    .wr_data   (wr_data),
    .rd_idx    (cmd_rd_idx),
    .rd_byte   (cmd_rd_data),
    .cmd_len   (cmd_len)
  );

  // R8: command-mode writes never move the FIFO count
  p_cmd_no_fifo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_WRITE_CMD) |=> count == $past(count));
  // R13: a held-off write beat never lands in either store
  p_stall_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && !cmd_clear) |=> cmd_len == $past(cmd_len));
endmodule

// File: tb/sim_pio_cmd_fifo.sv
`timescale 1ns/1ps
module sim_pio_cmd_fifo;
  localparam int D = 4;
  localparam int C = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 0, cmd_mode = 0, cmd_clear = 0, phase_dout = 0;
  logic wr_valid = 0, rd_req = 0, status_req = 0;
  logic [7:0] wr_data = 0, status_val = 0;
  logic [$clog2(C)-1:0] cmd_rd_idx = 0;
  logic wr_ready, rd_valid, irq, overrun;
  logic [7:0] rd_data, cmd_rd_data;
  logic [$clog2(C+1)-1:0] cmd_len;
  logic [$clog2(D+1)-1:0] count;
  logic [$clog2(D)-1:0] rd_ptr, wr_ptr;
  logic [4:0] flags;

  int total = 0, bad = 0;
  bit finished = 0;

  int mq [D];
  int cq [C];
  int m_cnt = 0, m_rp = 0, m_wp = 0, m_last = 0, m_flags = 0, m_clen = 0;

  always #2.5 clk = ~clk;

  pio_cmd_fifo #(.DEPTH(D), .CMD_DEPTH(C)) u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .cmd_mode(cmd_mode),
    .cmd_clear(cmd_clear), .phase_dout(phase_dout), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .rd_req(rd_req),
    .rd_valid(rd_valid), .rd_data(rd_data), .status_req(status_req),
    .status_val(status_val), .cmd_rd_idx(cmd_rd_idx),
    .cmd_rd_data(cmd_rd_data), .cmd_len(cmd_len), .count(count),
    .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .flags(flags), .irq(irq),
    .overrun(overrun)
  );

  task automatic check(input string tag, input int actual, input int expected);
    total++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  // One host action: drive at a falling edge, check one cycle later.
  task automatic step(input bit f, input bit s, input bit r, input bit w,
                      input bit cm, input bit dout, input bit clr,
                      input int d, input int sv);
    string tag;
    int e_irq = 0, e_ov = 0, e_rv = 0;
    @(negedge clk);
    flush = f; status_req = s; rd_req = r; wr_valid = w; cmd_mode = cm;
    phase_dout = dout; cmd_clear = clr; wr_data = 8'(d); status_val = 8'(sv);
    #1;
    check("R13 wr_ready", int'(wr_ready), int'(!(f || s || r)));
    tag = "R13 idle";
    if (f) begin
      m_cnt = 0; m_rp = 0; m_wp = 0; m_flags = 0; tag = "R12 flush";
    end else if (s) begin
      mq[0] = sv; mq[1] = 0; m_cnt = 2; m_rp = 0; m_wp = 2 % D;
      m_flags = 2; e_irq = 1; tag = "R11 status";
    end else if (r) begin
      e_rv = 1;
      if (m_cnt > 0) begin
        e_irq = 1;
        if (dout) begin m_last = 0; tag = "R5 dout read"; end
        else begin m_last = mq[m_rp]; m_rp = (m_rp + 1) % D; tag = "R4 read"; end
        m_cnt--;
        if (m_cnt == 0) begin m_rp = 0; m_wp = 0; tag = {tag, " R7 rewind"}; end
      end else begin
        tag = "R6 empty read";
      end
    end else if (w) begin
      if (cm) begin
        if (!clr && m_clen < C) begin cq[m_clen] = d; m_clen++; tag = "R8 cmd write"; end
        else tag = "R9 cmd full";
      end else if (m_cnt == D - 1) begin
        e_ov = 1; tag = "R3 overrun";
      end else begin
        mq[m_wp] = d; m_wp = (m_wp + 1) % D; m_cnt++; tag = "R2 write";
      end
    end
    if (clr) m_clen = 0;
    @(negedge clk);
    check({tag, " count"}, int'(count), m_cnt);
    check({tag, " rd_ptr"}, int'(rd_ptr), m_rp);
    check({tag, " wr_ptr"}, int'(wr_ptr), m_wp);
    check({tag, " rd_data"}, int'(rd_data), m_last);
    check({tag, " flags"}, int'(flags), m_flags);
    check({tag, " irq"}, int'(irq), e_irq);
    check({tag, " overrun"}, int'(overrun), e_ov);
    check({tag, " rd_valid"}, int'(rd_valid), e_rv);
    check({tag, clr ? " R10 cmd_len" : " cmd_len"}, int'(cmd_len), m_clen);
    flush = 0; status_req = 0; rd_req = 0; wr_valid = 0; cmd_mode = 0;
    phase_dout = 0; cmd_clear = 0;
  endtask

  task automatic wr(input int d);  step(0,0,0,1,0,0,0,d,0); endtask
  task automatic rd(input bit dout); step(0,0,1,0,0,dout,0,0,0); endtask

  initial begin
    #200000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < D; i++) mq[i] = 0;
    for (int i = 0; i < C; i++) cq[i] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 count", int'(count), 0);
    check("R1 rd_ptr", int'(rd_ptr), 0);
    check("R1 wr_ptr", int'(wr_ptr), 0);
    check("R1 cmd_len", int'(cmd_len), 0);
    check("R1 flags", int'(flags), 0);
    check("R1 rd_data", int'(rd_data), 0);
    check("R1 pulses", int'({irq, overrun, rd_valid}), 0);
    rst_n = 1'b1;

    // R2/R3/R4/R6/R7: every fill level, then full drain plus an empty read
    for (int n = 0; n <= D + 1; n++) begin
      for (int i = 0; i < n; i++) wr(16 * n + i + 1);
      for (int i = 0; i <= n; i++) rd(0);
    end

    // R2 pointer wrap: keep two bytes in flight across many positions
    wr(200); wr(201);
    for (int k = 0; k < 3 * D; k++) begin wr(100 + k); rd(0); end
    while (m_cnt > 0) rd(0);

    // R5 data-out reads at each position
    for (int p = 0; p < D - 1; p++) begin
      for (int i = 0; i < D - 1; i++) wr(50 + i);
      for (int i = 0; i < p; i++) rd(0);
      rd(1);
      while (m_cnt > 0) rd(0);
    end

    // R11 status response over a partly filled FIFO
    wr(7);
    step(0,1,0,0,0,0,0,0,8'hA5);
    rd(0); rd(0); rd(0);
    step(0,1,0,0,0,0,0,0,8'h3C);
    wr(9); wr(11);
    while (m_cnt > 0) rd(0);

    // R12 flush after writes and after a status
    wr(1); wr(2);
    step(1,0,0,0,0,0,0,0,0);
    step(0,1,0,0,0,0,0,0,8'h11);
    step(1,0,0,0,0,0,0,0,0);

    // R8/R9 command capture beyond capacity, FIFO untouched
    wr(33);
    for (int i = 0; i < C + 3; i++) step(0,0,0,1,1,0,0,70 + i,0);
    for (int i = 0; i < C; i++) begin
      cmd_rd_idx = ($clog2(C))'(i);
      #1;
      check("R9 cmd byte kept", int'(cmd_rd_data), cq[i]);
    end
    // R10 clear beats a simultaneous command write, then refill
    step(0,0,0,1,1,0,1,99,0);
    step(0,0,0,1,1,0,0,123,0);
    cmd_rd_idx = '0;
    #1;
    check("R8 cmd byte 0", int'(cmd_rd_data), 123);
    step(0,0,0,0,0,0,1,0,0);

    // R13 priority: read beats write, flush beats status, status beats read
    step(0,0,1,1,0,0,0,44,0);
    wr(45);
    step(1,1,0,0,0,0,0,0,8'h77);
    wr(46);
    step(0,1,1,1,0,0,0,47,8'h66);
    while (m_cnt > 0) rd(0);
    rd(0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule